// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a successive-approximation analog-to-digital converter. A start pulse opens a two-stage sample window. The first stage has a fixed length. The second stage has a length that software selects. After the window the sequencer walks a trial bit from the most significant position down to bit 0. It presents each trial word to an external DAC. It keeps or drops the trial bit according to an external comparator. At the end it outputs the result word and a one-cycle done strobe.

All timing counts in ticks of a conversion clock enable. A 5-bit prescaler divides the bus clock to make this enable. A single control write loads the prescaler code, the second-stage length and the resolution (8 or 10 bits) together. Any such write cancels a conversion that is running. The DAC, the comparator and the sampling capacitor are outside the block. So are channel selection and result storage.

Top module: `sar_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `dac_word` and `result` are all zero.
- R2: The conversion-clock tick period is 2×(`cfg_prescale`+1) bus cycles, so code 5 gives a period of 12. The sequencer state and `dac_word` change only on a tick.
- R3: The sample window lasts 2 ticks, then a further 2, 4, 8 or 16 ticks for `cfg_sample_sel` = 0, 1, 2 or 3. `dac_word` is zero throughout the window.
- R4: After the window, `dac_word` holds the bits already decided plus the current trial bit. The first trial word is the MSB weight alone. On each tick the trial bit is cleared if `cmp_above`=1, meaning the DAC is above the input. It is kept otherwise. The trial then moves one bit lower, ending at bit 0.
- R5: `done` rises in the cycle that follows the bus-clock edge lying exactly P×(2 + S2 + n) edges after the edge that captured `start`. Here P is the tick period, S2 is the second-stage length, and n is the resolution.
- R6: `cfg_low_res`=1 selects 8 bits: the trials cover bits 7..0 only, and bits 9:8 of both `dac_word` and `result` stay zero. `cfg_low_res`=0 selects 10 bits.
- R7: `done` is high for exactly one bus cycle. An accepted start clears `result` to zero. `result` then holds its value while the block is idle, until the next accepted start.
- R8: A `cfg_wr` cycle loads all three fields. If a conversion is running, it is aborted: `busy` is low in the next cycle and no `done` follows.
- R9: A `start` is ignored while `busy` is high. It is also ignored when it coincides with `cfg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe; loads the fields below and aborts a conversion |
| cfg_prescale | input | 5 | Prescaler code; tick period is 2×(code+1) |
| cfg_sample_sel | input | 2 | Second sample stage length select (2/4/8/16 ticks) |
| cfg_low_res | input | 1 | 1 = 8-bit, 0 = 10-bit resolution |
| start | input | 1 | Begin a conversion |
| cmp_above | input | 1 | Comparator: 1 when the DAC output exceeds the held input |
| dac_word | output | 10 | Trial word for the external DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 10 | Conversion result |

## Verification
The assertions assume that `cmp_above` is a function of the current `dac_word` and a held input. The assertion on `dac_word` stability during non-tick cycles holds only if the configuration changes through `cfg_wr` alone. The bench meets both assumptions. Its comparator model is combinational on `dac_word` against a fixed input value per conversion. It changes the control fields only together with a `cfg_wr` pulse. Random prescaler codes are kept small so that many conversions fit the run. Directed cases cover code 31, the longest sample stage, full-scale and zero inputs, an abort, and starts that must be ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SMP1 = 2'd1,
        ST_SMP2 = 2'd2,
        ST_CONV = 2'd3
    } sar_state_e;

    localparam int SMP1_TICKS = 2;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int PRS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRS_W-1:0] code,
    output logic             tick
);
    localparam int CNT_W = PRS_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = {code, 1'b1};
        tick  = run && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == limit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Period is at least 2, so ticks never occur back to back.
    assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int RES_W = 10,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             low_res,
    input  logic             cmp_above,
    output logic [RES_W-1:0] sar,
    output logic [RES_W-1:0] resolved,
    output logic             last
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] MSB_HI = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] MSB_LO = IDX_W'(LOW_W - 1);

    typedef struct packed {
        logic [RES_W-1:0] sar;
        logic [IDX_W-1:0] idx;
    } approx_t;

    approx_t st_d, st_q;

    always_comb begin
        resolved = st_q.sar;
        if (cmp_above) begin
            resolved[st_q.idx] = 1'b0;
        end
        st_d = st_q;
        if (init) begin
            st_d.idx = low_res ? MSB_LO : MSB_HI;
            st_d.sar = '0;
            st_d.sar[st_d.idx] = 1'b1;
        end else if (step) begin
            st_d.sar = resolved;
            if (st_q.idx != '0) begin
                st_d.idx = st_q.idx - 1'b1;
                st_d.sar[st_d.idx] = 1'b1;
            end
        end
        sar  = st_q.sar;
        last = (st_q.idx == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The first trial word holds exactly one set bit.
    assert_first_trial_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> ($countones(sar) == 1));
    // Trial bits below the current one are never set ahead of time.
    assert_no_step_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (sar == $past(resolved)));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int LOW_W = 8,
    parameter int PRS_W = 5,
    parameter int SMP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [PRS_W-1:0] cfg_prescale,
    input  logic [SMP_W-1:0] cfg_sample_sel,
    input  logic             cfg_low_res,
    input  logic             start,
    input  logic             cmp_above,
    output logic [RES_W-1:0] dac_word,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    localparam int SCNT_W = (1 << SMP_W) + 1;

    typedef struct packed {
        sar_state_e        state;
        logic [SCNT_W-1:0] cnt;
        logic [PRS_W-1:0]  prs;
        logic [SMP_W-1:0]  smp;
        logic              low_res;
        logic [RES_W-1:0]  result;
        logic              done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic             tick;
    logic             ap_init, ap_step, ap_last;
    logic [RES_W-1:0] ap_sar, ap_resolved;
    logic [SCNT_W-1:0] s2_len;

    sar_prescaler #(.PRS_W(PRS_W)) prescaler_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (c_q.state != ST_IDLE),
        .code (c_q.prs),
        .tick (tick)
    );

    sar_approx #(.RES_W(RES_W), .LOW_W(LOW_W)) approx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (ap_init),
        .step     (ap_step),
        .low_res  (c_q.low_res),
        .cmp_above(cmp_above),
        .sar      (ap_sar),
        .resolved (ap_resolved),
        .last     (ap_last)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        ap_init  = 1'b0;
        ap_step  = 1'b0;
        s2_len   = SCNT_W'(2) << c_q.smp;
        if (cfg_wr) begin
            c_d.prs     = cfg_prescale;
            c_d.smp     = cfg_sample_sel;
            c_d.low_res = cfg_low_res;
            c_d.state   = ST_IDLE;
            c_d.cnt     = '0;
        end else begin
            unique case (c_q.state)
                ST_IDLE: begin
                    if (start) begin
                        c_d.state  = ST_SMP1;
                        c_d.cnt    = '0;
                        c_d.result = '0;
                    end
                end
                ST_SMP1: begin
                    if (tick) begin
                        if (c_q.cnt == SCNT_W'(SMP1_TICKS - 1)) begin
                            c_d.state = ST_SMP2;
                            c_d.cnt   = '0;
                        end else begin
                            c_d.cnt = c_q.cnt + 1'b1;
                        end
                    end
                end
                ST_SMP2: begin
                    if (tick) begin
                        if (c_q.cnt == s2_len - 1'b1) begin
                            c_d.state = ST_CONV;
                            c_d.cnt   = '0;
                            ap_init   = 1'b1;
                        end else begin
                            c_d.cnt = c_q.cnt + 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        ap_step = 1'b1;
                        if (ap_last) begin
                            c_d.result = ap_resolved;
                            c_d.done   = 1'b1;
                            c_d.state  = ST_IDLE;
                        end
                    end
                end
                default: c_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign dac_word = (c_q.state == ST_CONV) ? ap_sar : '0;
    assign busy     = (c_q.state != ST_IDLE);
    assign done     = c_q.done;
    assign result   = c_q.result;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_result_held_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!busy && !done));
    assert_dac_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !cfg_wr) |=> $stable(dac_word));
    assert_low_res_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.low_res && !done) |=> (dac_word[RES_W-1:LOW_W] == '0));
    assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !cfg_wr && !tick) |=> busy);
endmodule

// File: tb/sar_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_ctrl_tb_top;
    localparam real CLK_NS = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_prescale = '0;
    logic [1:0] cfg_sample_sel = '0;
    logic       cfg_low_res = 1'b0;
    logic       start = 1'b0;
    logic       cmp_above;
    logic [9:0] dac_word;
    logic       busy, done;
    logic [9:0] result;
    int         vin = 0;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    assign cmp_above = (int'(dac_word) > vin);

    always @(negedge clk) if (done) done_seen++;

    sar_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_prescale(cfg_prescale),
        .cfg_sample_sel(cfg_sample_sel), .cfg_low_res(cfg_low_res), .start(start),
        .cmp_above(cmp_above), .dac_word(dac_word), .busy(busy), .done(done),
        .result(result)
    );

    function automatic int tick_period(int prs);
        return 2 * (prs + 1);
    endfunction

    function automatic int window_ticks(int smp);
        return 2 + (2 << smp);
    endfunction

    function automatic int total_cycles(int prs, int smp, bit low);
        return tick_period(prs) * (window_ticks(smp) + (low ? 8 : 10));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(int prs, int smp, bit low);
        @(negedge clk);
        cfg_prescale   = 5'(prs);
        cfg_sample_sel = 2'(smp);
        cfg_low_res    = low;
        cfg_wr         = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Runs one conversion; extra_start > 0 pulses start again at that cycle.
    task automatic run_conv(int prs, int smp, bit low, int v, int extra_start);
        int k = 0;
        int first_k = -1;
        int first_dac = 0;
        int exp_cyc = total_cycles(prs, smp, low);
        int r;
        write_cfg(prs, smp, low);
        vin = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && k < 4000) begin
            if (dac_word != 0 && first_k < 0) begin
                first_k = k;
                first_dac = int'(dac_word);
            end
            if (low) check(dac_word[9:8] == 2'b00, "R6", "dac upper bits", int'(dac_word[9:8]), 0);
            @(negedge clk);
            start = (k + 1 == extra_start);
            k++;
        end
        start = 1'b0;
        check(k == exp_cyc, "R5", "cycles to done", k, exp_cyc);
        check(first_k == tick_period(prs) * window_ticks(smp), "R3", "sample window cycles",
              first_k, tick_period(prs) * window_ticks(smp));
        check(first_dac == (low ? 128 : 512), "R4", "first trial word", first_dac, low ? 128 : 512);
        check(int'(result) == v, low ? "R6" : "R4", "result", int'(result), v);
        r = int'(result);
        @(negedge clk);
        check(done == 1'b0, "R7", "done width", int'(done), 0);
        repeat (3) @(negedge clk);
        check(int'(result) == r && !busy, "R7", "result held", int'(result), r);
    endtask

    initial begin
        #(CLK_NS * 150000.0);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && dac_word == 0 && result == 0, "R1", "reset outputs",
              int'(busy) + int'(done) + int'(dac_word) + int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: prescaler code 5 gives a 12-cycle tick
        run_conv(5, 0, 1'b0, 613, 0);
        check(total_cycles(5, 0, 1'b0) == 12 * 14, "R2", "code 5 period", total_cycles(5, 0, 1'b0), 168);
        // boundary cases
        run_conv(0, 0, 1'b0, 0, 0);
        run_conv(0, 3, 1'b0, 1023, 0);
        run_conv(1, 1, 1'b1, 255, 0);
        run_conv(0, 2, 1'b1, 0, 0);
        run_conv(31, 3, 1'b0, 341, 0);
        // R9: start while busy ignored
        run_conv(2, 1, 1'b0, 700, 20);

        // R9: start coincident with cfg_wr ignored
        @(negedge clk);
        start = 1'b1;
        cfg_wr = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_wr = 1'b0;
        check(!busy, "R9", "start with cfg_wr", int'(busy), 0);

        // R8: abort
        write_cfg(3, 2, 1'b0);
        vin = 400;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && result == 0, "R7", "start clears result", int'(result), 0);
        repeat (30) @(negedge clk);
        d0 = done_seen;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(!busy, "R8", "busy after abort", int'(busy), 0);
        repeat (600) @(negedge clk);
        check(done_seen == d0, "R8", "no done after abort", done_seen - d0, 0);
        check(dac_word == 0, "R8", "dac idle after abort", int'(dac_word), 0);

        // random conversions
        for (int i = 0; i < 40; i++) begin
            int prs = int'($urandom_range(0, 3));
            int smp = int'($urandom_range(0, 3));
            bit low = 1'($urandom_range(0, 1));
            int v = int'($urandom_range(0, low ? 255 : 1023));
            run_conv(prs, smp, low, v, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule